// File: doc/BRIEF.md
# Serial Receive Buffer with Per-Character Status

This block is the receive side of an asynchronous serial port, placed after the bit-level deserializer. The deserializer hands over a finished character together with the sampled first stop bit and the result of its parity check. The block holds the newest finished character in a single holding stage. It moves that character into a two-entry queue as soon as the queue has space. The error flags that belong to each character are stored next to it in the queue.

Software sees the block through a two-location read port: a status location and a data location. A read of the data location pops the queue. The status location always describes the character at the head of the queue, so software reads status first and data second. A level interrupt follows the "character available" flag while the interrupt enable is set.

When the queue is full, the holding stage still holds a character and another start bit arrives, the held character is dropped. The next character that enters the queue carries an overrun mark.

Top module: `uart_rx_buffer`

## Requirements
- R1: The `rxc` output is 1 exactly when the queue holds at least one unread character. A character given with `frame_done` in the cycle ending at edge k enters the holding stage at edge k. If the queue has room it enters the queue at edge k+1, and `rxc` is then 1.
- R2: While `rx_en` is 0, the queue and the holding stage are emptied on the next edge, the pending overrun mark is cleared, and `frame_done` is ignored. `rxc` therefore reads 0 after one edge and stays 0 after `rx_en` returns to 1.
- R3: `irq` equals `rxc_ie` AND `rxc`. Once raised, it stays high through any number of cycles and status reads. Only a data read or a disable clears it.
- R4: Address 0 is status and address 1 is data. The status bits are: bit 0 = rxc, bit 1 = frame error, bit 2 = overrun, bit 3 = parity error, and bits 7:4 are always 0. The error bits are those of the head character, and all read 0 when the queue is empty.
- R5: A data read (`rd_en`=1, `rd_addr`=1) while the queue is non-empty returns the head character and advances the head on that edge. Status afterwards describes the next character, in arrival order.
- R6: The frame-error bit of a character is the inverse of the `frame_stop1` value given with it.
- R7: A `start_det` pulse cancels the held character and sets a pending overrun mark when all of the following hold: the queue is full, the holding stage is occupied, and no data read happens in that cycle.
- R8: The next character that moves from the holding stage into the queue carries overrun = 1 and clears the pending mark. Characters after it carry overrun = 0.
- R9: The parity-error bit is `frame_par_bad` AND `par_en`, both taken at `frame_done`. Error bits never raise `irq`.
- R10: Writes to the status location (`st_wr_en` with any `st_wr_data`) change no status bit and no output.
- R11: A data read and a transfer from the holding stage in the same cycle lose neither character. The queue stays at the same depth, and the characters read out keep arrival order.
- R12: A data read while the queue is empty changes no state. The data location then shows the last character that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_en | input | 1 | Receiver enable; 0 empties the buffer |
| rxc_ie | input | 1 | Interrupt enable for character available |
| par_en | input | 1 | Parity checking enabled |
| start_det | input | 1 | One-cycle strobe: a start bit was detected |
| frame_done | input | 1 | One-cycle strobe: a character has been completed |
| frame_data | input | DATA_W | Completed character |
| frame_stop1 | input | 1 | Sampled value of the first stop bit |
| frame_par_bad | input | 1 | Parity check of the character failed |
| rd_en | input | 1 | Read strobe; pops when addressing data |
| rd_addr | input | 1 | 0 = status, 1 = data |
| rd_data | output | DATA_W | Read value for `rd_addr` (combinational) |
| st_wr_en | input | 1 | Write strobe to the status location |
| st_wr_data | input | DATA_W | Write value for the status location (no effect) |
| rxc | output | 1 | Character available |
| irq | output | 1 | Level interrupt |

## Verification
A completed character is in the holding stage one edge after its `frame_done` cycle. It reaches the queue, and raises `rxc` and `irq`, on the following edge. The bench therefore checks `rxc` as still low after the first edge and high after the second.

Pops, flushes and overrun decisions all take effect on the single edge that closes the strobe cycle. `rd_data` is combinational from the registered head, so the bench samples it a moment after setting `rd_addr`, in the same cycle. The bench drives every input two time units after a rising edge and reads outputs before the next one. The stop-bit, parity-enable and parity-result patterns are swept over all 256 data values.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

  typedef struct packed {
    logic pe;
    logic ovr;
    logic fe;
  } rxb_flags_t;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;

  localparam int ST_RXC = 0;
  localparam int ST_FE  = 1;
  localparam int ST_OVR = 2;
  localparam int ST_PE  = 3;

endpackage

// File: rtl/rxb_rst_sync.sv
module rxb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/rxb_shift.sv
module rxb_shift
  import uart_rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              start_det,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_stop1,
  input  logic              frame_par_bad,
  input  logic              buf_full,
  input  logic              pop,
  output logic              hold_valid,
  output logic              ovr_pend,
  output logic              overrun,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output rxb_flags_t        push_flags
);

  logic              valid_q, valid_n;
  logic              pend_q, pend_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              fe_q, fe_n;
  logic              pe_q, pe_n;
  logic              load_en;

  assign push    = rx_en && valid_q && (!buf_full || pop);
  assign overrun = rx_en && start_det && valid_q && buf_full && !pop;
  assign load_en = rx_en && frame_done;

  always_comb begin
    valid_n = valid_q;
    pend_n  = pend_q;
    if (!rx_en) begin
      valid_n = 1'b0;
      pend_n  = 1'b0;
    end else begin
      if (overrun)   pend_n = 1'b1;
      else if (push) pend_n = 1'b0;
      if (frame_done)                 valid_n = 1'b1;
      else if (push || overrun)       valid_n = 1'b0;
    end
  end

  always_comb begin
    data_n = data_q;
    fe_n   = fe_q;
    pe_n   = pe_q;
    if (load_en) begin
      data_n = frame_data;
      fe_n   = !frame_stop1;
      pe_n   = frame_par_bad && par_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= valid_n;
      pend_q  <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else if (load_en) begin
      data_q <= data_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
    end
  end

  assign hold_valid     = valid_q;
  assign ovr_pend       = pend_q;
  assign push_data      = data_q;
  assign push_flags.fe  = fe_q;
  assign push_flags.pe  = pe_q;
  assign push_flags.ovr = pend_q;

endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import uart_rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  rxb_flags_t                 push_flags,
  input  logic                       pop_req,
  output logic                       pop,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic [DATA_W-1:0]          head_data,
  output rxb_flags_t                 head_flags,
  output logic [DATA_W-1:0]          last_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slot_data [DEPTH];
  rxb_flags_t        slot_flags [DEPTH];

  logic [PW-1:0]     wr_ptr_q, wr_ptr_n;
  logic [PW-1:0]     rd_ptr_q, rd_ptr_n;
  logic [CW-1:0]     count_q, count_n;
  logic [DATA_W-1:0] last_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));
  assign pop   = pop_req && !empty && !flush;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    count_n  = count_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push) wr_ptr_n = bump(wr_ptr_q);
      if (pop)  rd_ptr_n = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_n = count_q + 1'b1;
        2'b01:   count_n = count_q - 1'b1;
        default: count_n = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      count_q  <= count_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && (wr_ptr_q == PW'(i))) begin
        slot_data[i]  <= push_data;
        slot_flags[i] <= push_flags;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= '0;
    else if (pop) last_q <= slot_data[rd_ptr_q];
  end

  assign head_data  = slot_data[rd_ptr_q];
  assign head_flags = slot_flags[rd_ptr_q];
  assign last_data  = last_q;
  assign count      = count_q;

endmodule

// File: rtl/rxb_regs.sv
module rxb_regs
  import uart_rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd_addr,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  rxb_flags_t        head_flags,
  input  logic [DATA_W-1:0] last_data,
  input  logic              rxc_ie,
  input  logic              st_wr_en,
  input  logic [DATA_W-1:0] st_wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rxc,
  output logic              irq
);

  logic [DATA_W-1:0] status;
  logic              unused_wr;

  assign unused_wr = st_wr_en ^ (^st_wr_data);
  assign rxc       = !empty;
  assign irq       = rxc_ie && rxc;

  always_comb begin
    status         = '0;
    status[ST_RXC] = rxc;
    if (rxc) begin
      status[ST_FE]  = head_flags.fe;
      status[ST_OVR] = head_flags.ovr;
      status[ST_PE]  = head_flags.pe;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_STATUS) rd_data = status;
    else if (rxc)               rd_data = head_data;
    else                        rd_data = last_data;
  end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxc_ie,
  input  logic              par_en,
  input  logic              start_det,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_stop1,
  input  logic              frame_par_bad,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_wr_en,
  input  logic [DATA_W-1:0] st_wr_data,
  output logic              rxc,
  output logic              irq
);

  localparam int CW = $clog2(DEPTH + 1);

  logic              rst_n_s;
  logic              pop_req, pop, push, overrun;
  logic              buf_full, buf_empty, hold_valid, ovr_pend;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] push_data, head_data, last_data;
  rxb_flags_t        push_flags, head_flags;

  assign pop_req = rd_en && (rd_addr == ADDR_DATA);

  rxb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  rxb_shift #(.DATA_W(DATA_W)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .rx_en         (rx_en),
    .par_en        (par_en),
    .start_det     (start_det),
    .frame_done    (frame_done),
    .frame_data    (frame_data),
    .frame_stop1   (frame_stop1),
    .frame_par_bad (frame_par_bad),
    .buf_full      (buf_full),
    .pop           (pop),
    .hold_valid    (hold_valid),
    .ovr_pend      (ovr_pend),
    .overrun       (overrun),
    .push          (push),
    .push_data     (push_data),
    .push_flags    (push_flags)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flush      (!rx_en),
    .push       (push),
    .push_data  (push_data),
    .push_flags (push_flags),
    .pop_req    (pop_req),
    .pop        (pop),
    .count      (count),
    .full       (buf_full),
    .empty      (buf_empty),
    .head_data  (head_data),
    .head_flags (head_flags),
    .last_data  (last_data)
  );

  rxb_regs #(.DATA_W(DATA_W)) u_regs (
    .rd_addr    (rd_addr),
    .empty      (buf_empty),
    .head_data  (head_data),
    .head_flags (head_flags),
    .last_data  (last_data),
    .rxc_ie     (rxc_ie),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .rd_data    (rd_data),
    .rxc        (rxc),
    .irq        (irq)
  );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n_s,
  input logic                       rx_en,
  input logic                       rxc_ie,
  input logic                       start_det,
  input logic                       frame_done,
  input logic                       pop_req,
  input logic                       pop,
  input logic                       push,
  input logic                       buf_full,
  input logic                       hold_valid,
  input logic                       ovr_pend,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       rxc,
  input logic                       irq
);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_flush_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rx_en |=> !rxc);

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq && rxc_ie && rx_en && !pop_req) |=> irq);

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_en && start_det && hold_valid && buf_full && !pop && !frame_done)
      |=> (ovr_pend && !hold_valid));

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> rxc);

  assert_swap_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_en && push && pop) |=> $stable(count));

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_en && pop_req && count == '0 && !push) |=> (count == '0));

endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .rx_en      (rx_en),
  .rxc_ie     (rxc_ie),
  .start_det  (start_det),
  .frame_done (frame_done),
  .pop_req    (pop_req),
  .pop        (pop),
  .push       (push),
  .buf_full   (buf_full),
  .hold_valid (hold_valid),
  .ovr_pend   (ovr_pend),
  .count      (count),
  .rxc        (rxc),
  .irq        (irq)
);

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;

  logic       clk = 1'b0;
  logic       rst_n, rx_en, rxc_ie, par_en;
  logic       start_det, frame_done, frame_stop1, frame_par_bad;
  logic [7:0] frame_data;
  logic       rd_en, rd_addr, st_wr_en;
  logic [7:0] st_wr_data, rd_data;
  logic       rxc, irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  uart_rx_buffer #(.DATA_W(8), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_ie(rxc_ie), .par_en(par_en),
    .start_det(start_det), .frame_done(frame_done), .frame_data(frame_data),
    .frame_stop1(frame_stop1), .frame_par_bad(frame_par_bad),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .rxc(rxc), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] st(input logic r, input logic fe, input logic ov, input logic pe);
    return {4'b0, pe, ov, fe, r};
  endfunction

  task automatic send(input logic [7:0] d, input logic stop1, input logic pbad, input logic pen);
    start_det = 1'b1;
    tick();
    start_det     = 1'b0;
    frame_done    = 1'b1;
    frame_data    = d;
    frame_stop1   = stop1;
    frame_par_bad = pbad;
    par_en        = pen;
    tick();
    frame_done = 1'b0;
  endtask

  task automatic peek_status(output logic [7:0] v);
    rd_addr = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic read_data(output logic [7:0] v);
    rd_addr = 1'b1;
    rd_en   = 1'b1;
    #1 v = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; rx_en = 1'b1; rxc_ie = 1'b0; par_en = 1'b0;
    start_det = 1'b0; frame_done = 1'b0; frame_data = '0;
    frame_stop1 = 1'b1; frame_par_bad = 1'b0;
    rd_en = 1'b0; rd_addr = 1'b0; st_wr_en = 1'b0; st_wr_data = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // reset state
    check("R1 reset rxc", rxc, 0);
    check("R3 reset irq", irq, 0);
    peek_status(v); check("R4 reset status", v, 0);

    // R1 arrival timing
    send(8'h3C, 1'b1, 1'b0, 1'b0);
    check("R1 rxc low while held", rxc, 0);
    tick();
    check("R1 rxc high after transfer", rxc, 1);
    read_data(v); check("R1 data", v, 8'h3C);
    check("R1 rxc low after read", rxc, 0);

    // sweep over all data values with stop/parity patterns: R4 R5 R6 R9
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      logic s1, pb, pen;
      d = 8'(i); s1 = d[0] ^ d[3]; pb = d[5]; pen = d[6];
      send(d, s1, pb, pen);
      tick();
      peek_status(v); check("R6 R9 sweep status", v, st(1'b1, !s1, 1'b0, pb & pen));
      read_data(v);   check("R5 sweep data", v, d);
      check("R1 sweep empty", rxc, 0);
    end

    // R5 ordering with two queued characters
    send(8'hA1, 1'b0, 1'b0, 1'b1); tick();
    send(8'hB2, 1'b1, 1'b1, 1'b1); tick();
    peek_status(v); check("R5 head first status", v, st(1, 1, 0, 0));
    read_data(v);   check("R5 first data", v, 8'hA1);
    peek_status(v); check("R5 second status", v, st(1, 0, 0, 1));
    read_data(v);   check("R5 second data", v, 8'hB2);

    // R7 R8 overrun
    send(8'h11, 1'b1, 1'b0, 1'b0); tick();
    send(8'h22, 1'b1, 1'b0, 1'b0); tick();
    send(8'h33, 1'b1, 1'b0, 1'b0); tick();
    start_det = 1'b1; tick(); start_det = 1'b0;
    peek_status(v); check("R7 head unaffected", v, st(1, 0, 0, 0));
    read_data(v);   check("R7 first kept", v, 8'h11);
    peek_status(v); check("R8 no mark before transfer", v, st(1, 0, 0, 0));
    send(8'h44, 1'b1, 1'b0, 1'b0); tick();
    read_data(v);   check("R7 second kept", v, 8'h22);
    peek_status(v); check("R8 mark carried", v, st(1, 0, 1, 0));
    read_data(v);   check("R7 held char dropped", v, 8'h44);
    check("R7 queue empty", rxc, 0);
    send(8'h55, 1'b1, 1'b0, 1'b0); tick();
    peek_status(v); check("R8 mark cleared", v, st(1, 0, 0, 0));
    read_data(v);   check("R8 data", v, 8'h55);

    // R11 simultaneous read and transfer
    send(8'h61, 1'b1, 1'b0, 1'b0); tick();
    send(8'h62, 1'b1, 1'b0, 1'b0); tick();
    send(8'h63, 1'b1, 1'b0, 1'b0); tick();
    read_data(v);   check("R11 first", v, 8'h61);
    read_data(v);   check("R11 second", v, 8'h62);
    check("R11 third still queued", rxc, 1);
    read_data(v);   check("R11 third", v, 8'h63);
    check("R11 empty", rxc, 0);

    // R12 empty read
    read_data(v);   check("R12 last value", v, 8'h63);
    check("R12 still empty", rxc, 0);
    peek_status(v); check("R12 status", v, 0);
    send(8'h70, 1'b1, 1'b0, 1'b0); tick();
    read_data(v);   check("R12 pointers intact", v, 8'h70);

    // R3 R10 interrupt and status writes
    rxc_ie = 1'b1;
    send(8'h81, 1'b0, 1'b0, 1'b0); tick();
    check("R3 irq raised", irq, 1);
    repeat (3) tick();
    peek_status(v);
    check("R3 irq held", irq, 1);
    st_wr_en = 1'b1; st_wr_data = 8'h00; tick();
    st_wr_data = 8'hFF; tick(); st_wr_en = 1'b0;
    peek_status(v); check("R10 write ignored", v, st(1, 1, 0, 0));
    check("R10 irq unchanged", irq, 1);
    read_data(v);   check("R3 data", v, 8'h81);
    check("R3 irq cleared by read", irq, 0);

    // R9 error bits raise no interrupt
    rxc_ie = 1'b0;
    send(8'h90, 1'b0, 1'b1, 1'b1); tick();
    peek_status(v); check("R9 flags present", v, st(1, 1, 0, 1));
    check("R9 no irq from errors", irq, 0);
    read_data(v);

    // R2 flush
    send(8'hA0, 1'b1, 1'b0, 1'b0); tick();
    send(8'hA1, 1'b1, 1'b0, 1'b0); tick();
    rx_en = 1'b0; tick();
    check("R2 flushed", rxc, 0);
    send(8'hA2, 1'b1, 1'b0, 1'b0);
    rx_en = 1'b1; repeat (2) tick();
    check("R2 frames ignored while off", rxc, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule